// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block sits beside a processor core and decides, once per clock, whether one of the waiting interrupt requests may be taken. Four kinds of input compete. Ordinary vectored requests come from a bank of maskable source lines. Each source has a group bit that places it in a high or a low priority class. Transfer-service requests come on a second, separate vector; they are served by a data-moving engine outside this block and never interrupt the program. The last input is a non-maskable request. Each kind follows its own admission rules.

A request pulse is latched until it is taken. A taken request produces a one-cycle accept strobe with the kind and source index. For a vectored or non-maskable accept, the block also saves the current "low-priority service" flag on a small internal stack, derives a new value for it, and drops the global enable. The core raises the enable again with an enable command, lowers it with a disable command, and signals the end of a handler with a return strobe, which restores the saved flag. A non-maskable accept also sets a sticky busy bit, which only a software clear command resets.

Top module: `nia_arbiter`

## Requirements
- R1: After synchronous reset: take=0, take_kind=0, ie=0, low_svc=1, nmi_busy=0, nest_depth=0, and no request is pending.
- R2: A vectored source i is accepted only while ie=1 and irq_mask[i]=0 (1 masks it). A request that is not eligible stays latched and is accepted once it becomes eligible.
- R3: Each vectored or non-maskable accept clears ie in the same edge that raises take. ei_cmd sets ie and di_cmd clears it, effective at the next edge. Accept takes precedence over di_cmd, and di_cmd over ei_cmd.
- R4: Among eligible vectored requests, a high-group source (grp_hi[i]=1) wins over any low-group source. Within one group the lowest index wins.
- R5: While low_svc=0, a high-priority handler is in service, and only high-group vectored requests may be accepted. Low-group requests stay pending.
- R6: A vectored accept pushes low_svc and then sets it to 1 for a low-group source and to 0 for a high-group source. A non-maskable accept pushes it and sets it to 0. reti_cmd pops the saved value back into low_svc. nest_depth counts the saved entries.
- R7: A non-maskable request is accepted whatever ie, the masks or low_svc are. Its accept sets nmi_busy. While nmi_busy=1, a new non-maskable request is held. nmis_clr resets nmi_busy, after which a held request is accepted.
- R8: A transfer-service request mac_req[i] is accepted whatever ie, low_svc, the masks, nmi_busy or a full stack are. It changes neither ie, low_svc nor nest_depth.
- R9: When several kinds are ready in the same cycle, the non-maskable request is taken first, a transfer-service request second and a vectored request last. Each is taken in its own cycle.
- R10: With nest_depth=DEPTH, vectored and non-maskable requests are held. No vectored or non-maskable request is accepted in a cycle with reti_cmd=1. reti_cmd with nest_depth=0 changes nothing.
- R11: take is a one-cycle strobe, and the accepted request's latch clears on the same edge. take_kind encodes 0 = none, 1 = non-maskable, 2 = transfer service, 3 = vectored. take_idx is the source index, or 0 for a non-maskable accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | N_SRC | Vectored request pulses, one per source |
| irq_mask | input | N_SRC | 1 masks the vectored source |
| grp_hi | input | N_SRC | 1 places the source in the high group |
| mac_req | input | N_SRC | Transfer-service request pulses |
| nmi_req | input | 1 | Non-maskable request pulse |
| ei_cmd | input | 1 | Enable command from the core |
| di_cmd | input | 1 | Disable command from the core |
| reti_cmd | input | 1 | Return-from-handler strobe |
| nmis_clr | input | 1 | Software clear of the non-maskable busy bit |
| take | output | 1 | Accept strobe |
| take_kind | output | 2 | Kind of the accepted request |
| take_idx | output | IW | Source index of the accepted request |
| ie | output | 1 | Global enable flag |
| low_svc | output | 1 | 1 when low-group requests may nest |
| nmi_busy | output | 1 | Non-maskable handler in service |
| nest_depth | output | CW | Number of saved service flags |

## Verification
A wrong saved flag stays hidden until the matching return strobe. After that strobe low_svc shows the wrong level at once, and a held low-group request is either taken one cycle early or never taken. A stale enable or busy bit shows up on the very next edge as an accept strobe that should not be there, or as one that is missing. A pending latch that fails to clear shows as a second strobe for the same source in the cycles that follow. The scoreboard catches each of these as an extra, missing or reordered accept.

// File: rtl/nia_pkg.sv
package nia_pkg;

    typedef enum logic [1:0] {
        TK_NONE  = 2'd0,
        TK_NMI   = 2'd1,
        TK_MACRO = 2'd2,
        TK_VECT  = 2'd3
    } take_kind_e;

    typedef struct packed {
        take_kind_e kind;
        logic       grp_bit;
    } pick_t;

    // Accepts that enter a handler save the service flag.
    function automatic logic kind_pushes(take_kind_e k);
        return (k == TK_NMI) || (k == TK_VECT);
    endfunction

    // Service flag after an accept that enters a handler.
    function automatic logic low_after(take_kind_e k, logic grp_bit);
        return (k == TK_VECT) ? !grp_bit : 1'b0;
    endfunction

endpackage

// File: rtl/nia_pend.sv
module nia_pend #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] live_o
);
    logic [N-1:0] held_q;

    assign live_o = held_q | set_i;

    always_ff @(posedge clk) begin
        if (rst) held_q <= '0;
        else     held_q <= live_o & ~clr_i;
    end
endmodule

// File: rtl/nia_pick.sv
module nia_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  cand_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        hit_o = |cand_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/nia_svc_stack.sv
module nia_svc_stack #(
    parameter int DEPTH = 4,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          val_i,
    output logic          top_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    logic [DEPTH-1:0] stk_q;
    logic [CW-1:0]    cnt_q;

    assign top_o   = stk_q[0];
    assign count_o = cnt_q;
    assign full_o  = (cnt_q == CW'(DEPTH));
    assign empty_o = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q <= '1;
            cnt_q <= '0;
        end else if (push_i && !full_o) begin
            for (int i = DEPTH - 1; i > 0; i--) stk_q[i] <= stk_q[i-1];
            stk_q[0] <= val_i;
            cnt_q    <= cnt_q + 1'b1;
        end else if (pop_i && !empty_o) begin
            for (int i = 0; i < DEPTH - 1; i++) stk_q[i] <= stk_q[i+1];
            stk_q[DEPTH-1] <= 1'b1;
            cnt_q          <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/nia_arbiter.sv
module nia_arbiter
    import nia_pkg::*;
#(
    parameter  int N_SRC = 8,
    parameter  int DEPTH = 4,
    localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_mask,
    input  logic [N_SRC-1:0] grp_hi,
    input  logic [N_SRC-1:0] mac_req,
    input  logic             nmi_req,
    input  logic             ei_cmd,
    input  logic             di_cmd,
    input  logic             reti_cmd,
    input  logic             nmis_clr,
    output logic             take,
    output logic [1:0]       take_kind,
    output logic [IW-1:0]    take_idx,
    output logic             ie,
    output logic             low_svc,
    output logic             nmi_busy,
    output logic [CW-1:0]    nest_depth
);
    logic [N_SRC-1:0] irq_live, mac_live, irq_clr, mac_clr;
    logic [N_SRC-1:0] vect_ok, hi_cand, lo_cand, sel_onehot;
    logic             nmi_live, nmi_clr_v;
    logic             hi_hit, lo_hit, mac_hit;
    logic [IW-1:0]    hi_idx, lo_idx, mac_idx, sel_idx;
    logic             stk_full, stk_empty, stk_top, can_nest, push;
    pick_t            sel;

    logic             take_q, ie_q, low_q, busy_q;
    take_kind_e       kind_q;
    logic [IW-1:0]    idx_q;

    // Request latches
    nia_pend #(.N(N_SRC)) u_irq_pend (
        .clk(clk), .rst(rst), .set_i(irq_req), .clr_i(irq_clr), .live_o(irq_live)
    );
    nia_pend #(.N(N_SRC)) u_mac_pend (
        .clk(clk), .rst(rst), .set_i(mac_req), .clr_i(mac_clr), .live_o(mac_live)
    );
    nia_pend #(.N(1)) u_nmi_pend (
        .clk(clk), .rst(rst), .set_i(nmi_req), .clr_i(nmi_clr_v), .live_o(nmi_live)
    );

    // Admission of vectored requests
    assign can_nest = !stk_full && !reti_cmd;
    assign vect_ok  = irq_live & ~irq_mask & {N_SRC{ie_q && can_nest}}
                    & (grp_hi | {N_SRC{low_q}});
    assign hi_cand  = vect_ok & grp_hi;
    assign lo_cand  = vect_ok & ~grp_hi;

    nia_pick #(.N(N_SRC), .IW(IW)) u_pick_hi  (.cand_i(hi_cand),  .hit_o(hi_hit),  .idx_o(hi_idx));
    nia_pick #(.N(N_SRC), .IW(IW)) u_pick_lo  (.cand_i(lo_cand),  .hit_o(lo_hit),  .idx_o(lo_idx));
    nia_pick #(.N(N_SRC), .IW(IW)) u_pick_mac (.cand_i(mac_live), .hit_o(mac_hit), .idx_o(mac_idx));

    // Class order: non-maskable, transfer service, high group, low group
    always_comb begin
        sel.kind = TK_NONE;
        sel_idx  = '0;
        if (nmi_live && !busy_q && can_nest) begin
            sel.kind = TK_NMI;
        end else if (mac_hit) begin
            sel.kind = TK_MACRO;
            sel_idx  = mac_idx;
        end else if (hi_hit) begin
            sel.kind = TK_VECT;
            sel_idx  = hi_idx;
        end else if (lo_hit) begin
            sel.kind = TK_VECT;
            sel_idx  = lo_idx;
        end
        sel.grp_bit = grp_hi[sel_idx];
    end

    assign sel_onehot = {{(N_SRC-1){1'b0}}, 1'b1} << sel_idx;
    assign irq_clr    = (sel.kind == TK_VECT)  ? sel_onehot : '0;
    assign mac_clr    = (sel.kind == TK_MACRO) ? sel_onehot : '0;
    assign nmi_clr_v  = (sel.kind == TK_NMI);
    assign push       = kind_pushes(sel.kind);

    nia_svc_stack #(.DEPTH(DEPTH), .CW(CW)) u_stack (
        .clk(clk), .rst(rst), .push_i(push), .pop_i(reti_cmd), .val_i(low_q),
        .top_o(stk_top), .count_o(nest_depth), .full_o(stk_full), .empty_o(stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
            kind_q <= TK_NONE;
            idx_q  <= '0;
            ie_q   <= 1'b0;
            low_q  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            take_q <= (sel.kind != TK_NONE);
            kind_q <= sel.kind;
            idx_q  <= sel_idx;

            if (push)        ie_q <= 1'b0;
            else if (di_cmd) ie_q <= 1'b0;
            else if (ei_cmd) ie_q <= 1'b1;

            if (push)                       low_q <= low_after(sel.kind, sel.grp_bit);
            else if (reti_cmd && !stk_empty) low_q <= stk_top;

            if (sel.kind == TK_NMI) busy_q <= 1'b1;
            else if (nmis_clr)      busy_q <= 1'b0;
        end
    end

    assign take      = take_q;
    assign take_kind = kind_q;
    assign take_idx  = idx_q;
    assign ie        = ie_q;
    assign low_svc   = low_q;
    assign nmi_busy  = busy_q;
endmodule

// File: rtl/nia_arbiter_chk.sv
module nia_arbiter_chk #(
    parameter  int N_SRC = 8,
    parameter  int DEPTH = 4,
    localparam int IW    = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic [N_SRC-1:0] grp_hi,
    input logic             reti_cmd,
    input logic             take,
    input logic [1:0]       take_kind,
    input logic [IW-1:0]    take_idx,
    input logic             ie,
    input logic             low_svc,
    input logic             nmi_busy,
    input logic [CW-1:0]    nest_depth
);
    logic             ie_prev, low_prev, busy_prev, reti_prev;
    logic [N_SRC-1:0] grp_prev;
    logic [CW-1:0]    depth_prev;

    always_ff @(posedge clk) begin
        ie_prev    <= ie;
        low_prev   <= low_svc;
        busy_prev  <= nmi_busy;
        reti_prev  <= reti_cmd;
        grp_prev   <= grp_hi;
        depth_prev <= nest_depth;
    end

    assert_vect_needs_ie_R2: assert property (@(posedge clk) disable iff (rst)
        (take && take_kind == 2'd3) |-> ie_prev);

    assert_accept_clears_ie_R3: assert property (@(posedge clk) disable iff (rst)
        (take && (take_kind == 2'd1 || take_kind == 2'd3)) |-> !ie);

    assert_high_only_nests_R5: assert property (@(posedge clk) disable iff (rst)
        (take && take_kind == 2'd3 && !low_prev) |-> grp_prev[take_idx]);

    assert_nmi_sets_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (take && take_kind == 2'd1) |-> (nmi_busy && !busy_prev));

    assert_macro_keeps_depth_R8: assert property (@(posedge clk) disable iff (rst)
        (take && take_kind == 2'd2 && !reti_prev) |-> (nest_depth == depth_prev));

    assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
        nest_depth <= CW'(DEPTH));

    assert_kind_tracks_take_R11: assert property (@(posedge clk) disable iff (rst)
        take == (take_kind != 2'd0));

    assert_vect_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        (take && take_kind == 2'd3) |=> !(take && take_kind == 2'd3));
endmodule

bind nia_arbiter nia_arbiter_chk #(.N_SRC(N_SRC), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .grp_hi(grp_hi), .reti_cmd(reti_cmd),
    .take(take), .take_kind(take_kind), .take_idx(take_idx), .ie(ie),
    .low_svc(low_svc), .nmi_busy(nmi_busy), .nest_depth(nest_depth)
);

// File: tb/nia_arbiter_tb_top.sv
module nia_arbiter_tb_top;
    localparam int N  = 8;
    localparam int D  = 4;
    localparam int K_NMI = 1, K_MAC = 2, K_VEC = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_req = '0, irq_mask = '0, grp_hi = '0, mac_req = '0;
    logic         nmi_req = 0, ei_cmd = 0, di_cmd = 0, reti_cmd = 0, nmis_clr = 0;
    logic         take, ie, low_svc, nmi_busy;
    logic [1:0]   take_kind;
    logic [2:0]   take_idx;
    logic [2:0]   nest_depth;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        int    kind;
        int    idx;
        string tag;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    nia_arbiter #(.N_SRC(N), .DEPTH(D)) dut_i (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_mask(irq_mask),
        .grp_hi(grp_hi), .mac_req(mac_req), .nmi_req(nmi_req),
        .ei_cmd(ei_cmd), .di_cmd(di_cmd), .reti_cmd(reti_cmd), .nmis_clr(nmis_clr),
        .take(take), .take_kind(take_kind), .take_idx(take_idx), .ie(ie),
        .low_svc(low_svc), .nmi_busy(nmi_busy), .nest_depth(nest_depth)
    );

    // Monitor: every accept strobe must match the oldest expected item
    always @(negedge clk) begin
        if (!rst && take) begin
            n_chk++;
            if (expq.size() == 0) begin
                n_bad++;
                $display("FAIL R11 unexpected accept: actual kind=%0d idx=%0d expected none",
                         take_kind, take_idx);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (take_kind != 2'(e.kind) || int'(take_idx) != e.idx) begin
                    n_bad++;
                    $display("FAIL %s: actual kind=%0d idx=%0d expected kind=%0d idx=%0d",
                             e.tag, take_kind, take_idx, e.kind, e.idx);
                end
            end
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic expect_take(int kind, int idx, string tag);
        exp_t e;
        e.kind = kind;
        e.idx  = idx;
        e.tag  = tag;
        expq.push_back(e);
    endtask

    task automatic pulse_irq(logic [N-1:0] v);
        irq_req = v; tick(); irq_req = '0;
    endtask
    task automatic pulse_mac(logic [N-1:0] v);
        mac_req = v; tick(); mac_req = '0;
    endtask
    task automatic pulse_nmi();
        nmi_req = 1'b1; tick(); nmi_req = 1'b0;
    endtask
    task automatic do_ei();
        ei_cmd = 1'b1; tick(); ei_cmd = 1'b0; tick(3);
    endtask
    task automatic do_di();
        di_cmd = 1'b1; tick(); di_cmd = 1'b0; tick(3);
    endtask
    task automatic do_ret();
        reti_cmd = 1'b1; tick(); reti_cmd = 1'b0; tick(3);
    endtask
    task automatic do_nclr();
        nmis_clr = 1'b1; tick(); nmis_clr = 1'b0; tick(3);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 take", take, 0);
        chk("R1 kind", take_kind, 0);
        chk("R1 ie", ie, 0);
        chk("R1 low_svc", low_svc, 1);
        chk("R1 nmi_busy", nmi_busy, 0);
        chk("R1 depth", nest_depth, 0);

        // R2: held while ie=0, exact strobe timing R11
        pulse_irq(8'h08);
        tick(3);
        chk("R2 no accept with ie=0", nest_depth, 0);
        expect_take(K_VEC, 3, "R2 held request taken after enable");
        ei_cmd = 1'b1; tick(); ei_cmd = 1'b0;
        chk("R3 ei sets ie", ie, 1);
        chk("R11 no strobe before accept edge", take, 0);
        tick();
        chk("R11 strobe high", take, 1);
        chk("R3 accept clears ie", ie, 0);
        chk("R6 depth after accept", nest_depth, 1);
        tick();
        chk("R11 strobe one cycle", take, 0);
        chk("R6 low source keeps low_svc", low_svc, 1);
        do_ret();
        chk("R6 depth after return", nest_depth, 0);

        // R4: lowest index inside a group
        pulse_irq(8'h24);
        tick(2);
        expect_take(K_VEC, 2, "R4 lowest index first");
        do_ei();
        expect_take(K_VEC, 5, "R4 next index second");
        do_ei();
        chk("R4 two nested", nest_depth, 2);
        do_ret();
        do_ret();

        // R4/R5/R6: high group wins and blocks low group
        grp_hi = 8'h40;
        do_ei();
        expect_take(K_VEC, 6, "R4 high group wins");
        pulse_irq(8'h42);
        tick(3);
        chk("R6 high source clears low_svc", low_svc, 0);
        do_ei();
        tick(2);
        chk("R5 low request held, ie stays", ie, 1);
        chk("R5 low request held, depth", nest_depth, 1);
        grp_hi = 8'hC0;
        expect_take(K_VEC, 7, "R5 high request nests");
        pulse_irq(8'h80);
        tick(3);
        chk("R5 nested depth", nest_depth, 2);
        do_ret();
        chk("R6 restore inner flag", low_svc, 0);
        do_ret();
        chk("R6 restore outer flag", low_svc, 1);
        chk("R6 depth empty", nest_depth, 0);
        expect_take(K_VEC, 1, "R2 pending low request taken later");
        do_ei();
        chk("R2 late accept depth", nest_depth, 1);
        do_ret();

        // R2: mask
        do_ei();
        irq_mask = 8'h10;
        pulse_irq(8'h10);
        tick(3);
        chk("R2 masked request ignored", ie, 1);
        expect_take(K_VEC, 4, "R2 unmasked request taken");
        irq_mask = '0;
        tick(3);
        chk("R2 unmask accept depth", nest_depth, 1);
        do_ret();

        // R7: non-maskable
        irq_mask = 8'hFF;
        expect_take(K_NMI, 0, "R7 nmi with ie=0 and masks");
        pulse_nmi();
        tick(3);
        chk("R7 busy set", nmi_busy, 1);
        chk("R6 nmi clears low_svc", low_svc, 0);
        chk("R7 nmi depth", nest_depth, 1);
        pulse_nmi();
        tick(3);
        chk("R7 second nmi held", nest_depth, 1);
        expect_take(K_NMI, 0, "R7 held nmi after clear");
        do_nclr();
        chk("R7 held nmi accepted", nest_depth, 2);
        chk("R7 busy again", nmi_busy, 1);
        do_ret();
        do_ret();
        do_nclr();
        chk("R7 busy cleared", nmi_busy, 0);
        chk("R6 flag restored after nmi", low_svc, 1);
        irq_mask = '0;

        // R8: transfer service
        expect_take(K_MAC, 5, "R8 service with ie=0");
        pulse_mac(8'h20);
        tick(3);
        chk("R8 ie untouched", ie, 0);
        chk("R8 depth untouched", nest_depth, 0);
        do_ei();
        expect_take(K_VEC, 6, "R8 setup high handler");
        pulse_irq(8'h40);
        tick(3);
        expect_take(K_MAC, 1, "R8 service in high handler");
        pulse_mac(8'h02);
        tick(3);
        chk("R8 depth in handler", nest_depth, 1);
        chk("R8 low_svc kept", low_svc, 0);
        do_ret();

        // R9: same-cycle order
        grp_hi = '0;
        do_ei();
        expect_take(K_NMI, 0, "R9 nmi first");
        expect_take(K_MAC, 2, "R9 service second");
        nmi_req = 1'b1; mac_req = 8'h04; irq_req = 8'h01;
        tick();
        nmi_req = 1'b0; mac_req = '0; irq_req = '0;
        tick(3);
        chk("R9 vectored held", nest_depth, 1);
        do_ret();
        expect_take(K_VEC, 0, "R9 vectored last");
        do_ei();
        chk("R9 vectored depth", nest_depth, 1);
        do_ret();
        do_nclr();

        // R10: full stack
        for (int i = 0; i < D; i++) begin
            expect_take(K_VEC, i, "R10 fill stack");
            do_ei();
            pulse_irq(8'(1 << i));
            tick(2);
        end
        chk("R10 stack full", nest_depth, D);
        do_ei();
        pulse_irq(8'h10);
        pulse_nmi();
        tick(3);
        chk("R10 held while full, depth", nest_depth, D);
        chk("R10 held while full, ie", ie, 1);
        expect_take(K_MAC, 7, "R8 service while full");
        pulse_mac(8'h80);
        tick(3);
        chk("R8 depth while full", nest_depth, D);
        expect_take(K_NMI, 0, "R10 nmi after return frees slot");
        do_ret();
        chk("R10 refilled", nest_depth, D);
        chk("R10 nmi cleared ie", ie, 0);
        do_ret();
        expect_take(K_VEC, 4, "R10 vectored after slot freed");
        do_ei();
        chk("R10 refilled by vectored", nest_depth, D);
        for (int i = 0; i < D; i++) do_ret();
        do_nclr();
        chk("R10 drained", nest_depth, 0);
        do_ret();
        chk("R10 return on empty depth", nest_depth, 0);
        chk("R10 return on empty flag", low_svc, 1);

        // R3: enable commands
        do_ei();
        chk("R3 ei", ie, 1);
        do_di();
        chk("R3 di", ie, 0);
        ei_cmd = 1'b1; di_cmd = 1'b1; tick(); ei_cmd = 1'b0; di_cmd = 1'b0; tick(2);
        chk("R3 di beats ei", ie, 0);

        tick(5);
        chk("R11 every expected accept seen", expq.size(), 0);
        finish_run();
    end
endmodule